// File: doc/BRIEF.md
# JTAG Debug Port Access Logic

This block is the target side of a JTAG debug port. A TAP controller, clocked by `tck`, selects one of several data registers through a 4-bit instruction register. Two access registers carry 35-bit frames. One reaches the debug-port registers: control/status, AP select and the read buffer. The other launches accesses to an access port over a level request / pulse acknowledge handshake. An identification register and a one-bit bypass register complete the scan set. An abort register cancels an access that is hanging.

Reads are posted. A scan that requests a read captures the result of the earlier read, and that result is collected later through the read buffer. Every access scan returns a 3-bit response in its capture phase. While an access-port transfer is still open, access scans are answered with WAIT and their contents are thrown away. An optional overrun flag records each WAIT. An error reported by the access port sets a sticky flag. While either sticky flag is set, access-port requests are refused. Software clears the flags by writing ones to them.

Top module: `dbgp_port`

## Requirements
- R1: The TAP follows the standard 16-state graph. Five TCK cycles with TMS high reach Test-Logic-Reset, and that state loads the instruction 0xE. Capture-IR loads 4'b0001.
- R2: Instruction 0xE selects a 32-bit identification register holding the IDCODE parameter, shifted LSB first. Any code other than 0x8, 0xA, 0xB or 0xE selects a 1-bit bypass register that captures 0.
- R3: Instructions 0xA (DP access) and 0xB (AP access) select a 35-bit frame. Shift order is bit 0 = read flag (1 = read), bits 2:1 = register address, bits 34:3 = data. Capture loads bits 2:0 with the response (3'b010 OK, 3'b001 WAIT) and bits 34:3 with the read buffer, which holds the result of the previous read.
- R4: DP address 2'b01 is control/status, 2'b10 is AP select and 2'b11 is the read buffer. A read-buffer read leaves it unchanged. Writes to the read buffer and to address 2'b00 are ignored. A read of address 2'b00 loads 0 into the read buffer.
- R5: In the AP select register, bits 31:24 are the AP number and bits 7:4 are the bank. All other bits read back as 0. The AP address driven out is {AP number, bank, frame address}.
- R6: An AP access that is accepted at Update-DR raises `ap_req` with its address, direction (`ap_wnr`=1 for write) and data. The request holds steady until `ap_ack`. On acknowledge, a read loads `ap_rdata` into the read buffer.
- R7: An access scan whose capture sees a request still open returns WAIT, and its update has no effect.
- R8: Control/status bit 0 enables overrun detection. A WAIT response while it is set sets the sticky overrun flag, bit 1.
- R9: `ap_err` with `ap_ack` sets the sticky error flag, bit 5. While bit 1 or bit 5 is set, AP access scans return OK but launch nothing.
- R10: Writing control/status with a 1 in bit 1 or bit 5 clears that flag. A 0 leaves it as it is.
- R11: Instruction 0x8 selects a 35-bit abort frame that always captures OK. An update with data equal to 1 drops any open request and pulses `ap_abort` for one cycle. Any other data value has no effect.
- R12: Control/status bits 28 and 30 are writable power requests. Bits 29 and 31 are their acknowledges, each copying its request one cycle later.
- R13: `tdo` carries bit 0 of the active shift register in Shift-IR and Shift-DR, and is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| ap_req | output | 1 | AP access request, held until acknowledge or abort |
| ap_wnr | output | 1 | 1 = write, 0 = read |
| ap_addr | output | 14 | {AP number, bank, register address} |
| ap_wdata | output | 32 | Write data |
| ap_ack | input | 1 | One-cycle completion pulse |
| ap_rdata | input | 32 | Read data, valid with ap_ack |
| ap_err | input | 1 | Error flag, valid with ap_ack |
| ap_abort | output | 1 | One-cycle pulse when an access is aborted |

## Verification
The bench checks posted reads. A design that returned current rather than previous data would fail both the back-to-back AP read check and the read-buffer re-read check. It holds the access port busy to force WAIT, and then confirms that no second transfer reaches the port and that overrun is recorded only when detection is enabled. A design that let writes through during WAIT, or that ignored the sticky gate, would show an extra transfer. It also checks that abort with a value other than 1 leaves the request standing, that W1C writes clear only the named flags, and that masked select bits read back as 0.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam int IR_W   = 4;
  localparam int ACK_W  = 3;
  localparam int DATA_W = 32;
  localparam int ACC_W  = ACK_W + DATA_W;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] INS_ABORT = 4'h8;
  localparam logic [IR_W-1:0] INS_DPACC = 4'hA;
  localparam logic [IR_W-1:0] INS_APACC = 4'hB;
  localparam logic [IR_W-1:0] INS_ID    = 4'hE;
  localparam logic [IR_W-1:0] IR_CAP    = 4'b0001;

  localparam logic [ACK_W-1:0] RSP_OK   = 3'b010;
  localparam logic [ACK_W-1:0] RSP_WAIT = 3'b001;

  localparam logic [1:0] DPA_NONE = 2'b00;
  localparam logic [1:0] DPA_CS   = 2'b01;
  localparam logic [1:0] DPA_SEL  = 2'b10;
  localparam logic [1:0] DPA_RDB  = 2'b11;

  // control/status bit positions
  localparam int CS_ODET  = 0;
  localparam int CS_SORUN = 1;
  localparam int CS_SERR  = 5;
  localparam int CS_DREQ  = 28;
  localparam int CS_DACK  = 29;
  localparam int CS_SREQ  = 30;
  localparam int CS_SACK  = 31;
  localparam int SEL_BANK_LSB = 4;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [1:0]        addr;
    logic              rnw;
  } acc_frame_t;
endpackage

// File: rtl/dbgp_rst_sync.sv
module dbgp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dbgp_tap_fsm.sv
module dbgp_tap_fsm
  import dbgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_RESET:  state_d = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   state_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: state_d = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: state_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  state_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: state_d = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: state_d = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: state_d = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: state_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: state_d = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: state_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  state_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: state_d = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: state_d = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: state_d = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: state_d = tms ? TS_SEL_DR : TS_IDLE;
      default:   state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TS_RESET;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dbgp_scan.sv
module dbgp_scan
  import dbgp_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDCODE = 32'h1E5A_7C01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  logic              tdi,
  input  logic [ACC_W-1:0]  cap_acc,
  output logic [IR_W-1:0]   ir_o,
  output logic [ACC_W-1:0]  dr_o,
  output logic              tdo
);
  logic [IR_W-1:0]  ir_sr_q, ir_sr_d, ir_q, ir_d;
  logic [ACC_W-1:0] dr_q, dr_d, dr_shifted, dr_cap;
  int unsigned      dr_len;

  // length and capture value of the selected data register
  always_comb begin
    unique case (ir_q)
      INS_DPACC, INS_APACC: begin dr_len = ACC_W;  dr_cap = cap_acc; end
      INS_ABORT:            begin dr_len = ACC_W;  dr_cap = {{DATA_W{1'b0}}, RSP_OK}; end
      INS_ID:               begin dr_len = DATA_W; dr_cap = {{ACK_W{1'b0}}, IDCODE}; end
      default:              begin dr_len = 1;      dr_cap = '0; end
    endcase
  end

  assign dr_shifted = {1'b0, dr_q[ACC_W-1:1]};

  always_comb begin
    dr_d = dr_q;
    if (state == TS_CAP_DR) begin
      dr_d = dr_cap;
    end else if (state == TS_SH_DR) begin
      for (int i = 0; i < ACC_W; i++) begin
        if (i == int'(dr_len) - 1)     dr_d[i] = tdi;
        else if (i < int'(dr_len) - 1) dr_d[i] = dr_shifted[i];
        else                           dr_d[i] = dr_q[i];
      end
    end
  end

  always_comb begin
    ir_sr_d = ir_sr_q;
    ir_d    = ir_q;
    if (state == TS_CAP_IR)     ir_sr_d = IR_CAP;
    else if (state == TS_SH_IR) ir_sr_d = {tdi, ir_sr_q[IR_W-1:1]};
    if (state == TS_RESET)      ir_d = INS_ID;
    else if (state == TS_UPD_IR) ir_d = ir_sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr_q <= '0;
      ir_q    <= INS_ID;
      dr_q    <= '0;
    end else begin
      ir_sr_q <= ir_sr_d;
      ir_q    <= ir_d;
      dr_q    <= dr_d;
    end
  end

  always_comb begin
    unique case (state)
      TS_SH_IR: tdo = ir_sr_q[0];
      TS_SH_DR: tdo = dr_q[0];
      default:  tdo = 1'b0;
    endcase
  end

  assign ir_o = ir_q;
  assign dr_o = dr_q;
endmodule

// File: rtl/dbgp_core.sv
module dbgp_core
  import dbgp_pkg::*;
#(
  parameter int APSEL_W = 8,
  parameter int BANK_W  = 4,
  localparam int AW     = APSEL_W + BANK_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  logic [IR_W-1:0]   ir,
  input  logic [ACC_W-1:0]  dr,
  output logic [ACC_W-1:0]  cap_acc,
  output logic              ap_req,
  output logic              ap_wnr,
  output logic [AW-1:0]     ap_addr,
  output logic [DATA_W-1:0] ap_wdata,
  input  logic              ap_ack,
  input  logic [DATA_W-1:0] ap_rdata,
  input  logic              ap_err,
  output logic              ap_abort,
  output logic [1:0]        pwr_req,
  output logic [1:0]        pwr_ack
);
  acc_frame_t frame;
  assign frame = acc_frame_t'(dr);

  logic              req_q, req_d, rd_q, rd_d, wait_q, wait_d, abort_q, abort_d;
  logic              odet_q, odet_d, sorun_q, sorun_d, serr_q, serr_d;
  logic [1:0]        preq_q, preq_d, pack_q;
  logic [APSEL_W-1:0] sel_ap_q, sel_ap_d;
  logic [BANK_W-1:0] sel_bank_q, sel_bank_d;
  logic [DATA_W-1:0] rdbuff_q, rdbuff_d;
  logic              rdbuff_en, launch;
  logic [DATA_W-1:0] ctrl_val, sel_val;
  logic              is_acc, upd;

  assign is_acc = (ir == INS_DPACC) || (ir == INS_APACC);
  assign upd    = (state == TS_UPD_DR);

  always_comb begin
    ctrl_val           = '0;
    ctrl_val[CS_ODET]  = odet_q;
    ctrl_val[CS_SORUN] = sorun_q;
    ctrl_val[CS_SERR]  = serr_q;
    ctrl_val[CS_DREQ]  = preq_q[0];
    ctrl_val[CS_DACK]  = pack_q[0];
    ctrl_val[CS_SREQ]  = preq_q[1];
    ctrl_val[CS_SACK]  = pack_q[1];
    sel_val            = '0;
    sel_val[DATA_W-1 -: APSEL_W]    = sel_ap_q;
    sel_val[SEL_BANK_LSB +: BANK_W] = sel_bank_q;
  end

  assign cap_acc = {rdbuff_q, (req_q ? RSP_WAIT : RSP_OK)};

  always_comb begin
    req_d      = req_q;
    rd_d       = rd_q;
    wait_d     = wait_q;
    abort_d    = 1'b0;
    odet_d     = odet_q;
    sorun_d    = sorun_q;
    serr_d     = serr_q;
    preq_d     = preq_q;
    sel_ap_d   = sel_ap_q;
    sel_bank_d = sel_bank_q;
    rdbuff_d   = rdbuff_q;
    rdbuff_en  = 1'b0;
    launch     = 1'b0;

    if (state == TS_CAP_DR) wait_d = is_acc && req_q;

    // completion of the open access-port transfer
    if (req_q && ap_ack) begin
      req_d = 1'b0;
      if (rd_q) begin rdbuff_d = ap_rdata; rdbuff_en = 1'b1; end
      if (ap_err) serr_d = 1'b1;
    end

    if (upd) begin
      if (is_acc && wait_q) begin
        if (odet_q) sorun_d = 1'b1;
      end else if (ir == INS_DPACC) begin
        if (frame.rnw) begin
          unique case (frame.addr)
            DPA_CS:   begin rdbuff_d = ctrl_val; rdbuff_en = 1'b1; end
            DPA_SEL:  begin rdbuff_d = sel_val;  rdbuff_en = 1'b1; end
            DPA_RDB:  ;
            default:  begin rdbuff_d = '0;       rdbuff_en = 1'b1; end
          endcase
        end else begin
          unique case (frame.addr)
            DPA_CS: begin
              odet_d = frame.data[CS_ODET];
              if (frame.data[CS_SORUN]) sorun_d = 1'b0;
              if (frame.data[CS_SERR])  serr_d  = 1'b0;
              preq_d = {frame.data[CS_SREQ], frame.data[CS_DREQ]};
            end
            DPA_SEL: begin
              sel_ap_d   = frame.data[DATA_W-1 -: APSEL_W];
              sel_bank_d = frame.data[SEL_BANK_LSB +: BANK_W];
            end
            default: ;
          endcase
        end
      end else if (ir == INS_APACC) begin
        if (!sorun_q && !serr_q) begin
          launch = 1'b1;
          req_d  = 1'b1;
          rd_d   = frame.rnw;
        end
      end else if (ir == INS_ABORT && frame.data == {{(DATA_W-1){1'b0}}, 1'b1}) begin
        req_d   = 1'b0;
        abort_d = 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      rd_q       <= 1'b0;
      wait_q     <= 1'b0;
      abort_q    <= 1'b0;
      odet_q     <= 1'b0;
      sorun_q    <= 1'b0;
      serr_q     <= 1'b0;
      preq_q     <= '0;
      pack_q     <= '0;
      sel_ap_q   <= '0;
      sel_bank_q <= '0;
    end else begin
      req_q      <= req_d;
      rd_q       <= rd_d;
      wait_q     <= wait_d;
      abort_q    <= abort_d;
      odet_q     <= odet_d;
      sorun_q    <= sorun_d;
      serr_q     <= serr_d;
      preq_q     <= preq_d;
      pack_q     <= preq_q;
      sel_ap_q   <= sel_ap_d;
      sel_bank_q <= sel_bank_d;
    end
  end

  // data registers with written-out enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdbuff_q <= '0;
      ap_addr  <= '0;
      ap_wdata <= '0;
      ap_wnr   <= 1'b0;
    end else begin
      if (rdbuff_en) rdbuff_q <= rdbuff_d;
      if (launch) begin
        ap_addr  <= {sel_ap_q, sel_bank_q, frame.addr};
        ap_wdata <= frame.data;
        ap_wnr   <= ~frame.rnw;
      end
    end
  end

  assign ap_req   = req_q;
  assign ap_abort = abort_q;
  assign pwr_req  = preq_q;
  assign pwr_ack  = pack_q;
endmodule

// File: rtl/dbgp_port.sv
module dbgp_port
  import dbgp_pkg::*;
#(
  parameter logic [31:0] IDCODE  = 32'h1E5A_7C01,
  parameter int          APSEL_W = 8,
  parameter int          BANK_W  = 4,
  localparam int         AW      = APSEL_W + BANK_W + 2
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          tms,
  input  logic          tdi,
  output logic          tdo,
  output logic          ap_req,
  output logic          ap_wnr,
  output logic [AW-1:0] ap_addr,
  output logic [31:0]   ap_wdata,
  input  logic          ap_ack,
  input  logic [31:0]   ap_rdata,
  input  logic          ap_err,
  output logic          ap_abort
);
  logic             rst_n_s;
  tap_state_e       tap_state;
  logic [IR_W-1:0]  ir_q;
  logic [ACC_W-1:0] dr_q, cap_acc;
  logic [1:0]       pwr_req, pwr_ack;

  dbgp_rst_sync #(.STAGES(2)) u_rst (
    .clk(tck), .arst_n(trst_n), .rst_n_o(rst_n_s)
  );

  dbgp_tap_fsm u_tap (
    .clk(tck), .rst_n(rst_n_s), .tms(tms), .state_o(tap_state)
  );

  dbgp_scan #(.IDCODE(IDCODE)) u_scan (
    .clk(tck), .rst_n(rst_n_s), .state(tap_state), .tdi(tdi),
    .cap_acc(cap_acc), .ir_o(ir_q), .dr_o(dr_q), .tdo(tdo)
  );

  dbgp_core #(.APSEL_W(APSEL_W), .BANK_W(BANK_W)) u_core (
    .clk(tck), .rst_n(rst_n_s), .state(tap_state), .ir(ir_q), .dr(dr_q),
    .cap_acc(cap_acc), .ap_req(ap_req), .ap_wnr(ap_wnr), .ap_addr(ap_addr),
    .ap_wdata(ap_wdata), .ap_ack(ap_ack), .ap_rdata(ap_rdata), .ap_err(ap_err),
    .ap_abort(ap_abort), .pwr_req(pwr_req), .pwr_ack(pwr_ack)
  );
endmodule

// File: rtl/dbgp_port_chk.sv
module dbgp_port_chk
  import dbgp_pkg::*;
#(
  parameter int AW = 14
) (
  input logic            clk,
  input logic            rst_n,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir,
  input logic            tdo,
  input logic            ap_req,
  input logic            ap_ack,
  input logic            ap_abort,
  input logic            ap_wnr,
  input logic [AW-1:0]   ap_addr,
  input logic [31:0]     ap_wdata,
  input logic [1:0]      pwr_req,
  input logic [1:0]      pwr_ack
);
  // R1
  ir_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == TS_RESET |=> ir == INS_ID);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req && !ap_ack |=> ap_req || ap_abort);

  // R6
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req && !ap_ack |=> !ap_req || ($stable(ap_addr) && $stable(ap_wdata) && $stable(ap_wnr)));

  // R6
  req_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ap_req) |-> ($past(state) == TS_UPD_DR && $past(ir) == INS_APACC));

  // R11
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_abort |-> !ap_req);

  // R12
  pwr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pwr_ack == $past(pwr_req));

  // R13
  tdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == TS_SH_DR || state == TS_SH_IR) |-> !tdo);
endmodule

bind dbgp_port dbgp_port_chk #(.AW(AW)) u_chk (
  .clk(tck), .rst_n(rst_n_s), .state(tap_state), .ir(ir_q), .tdo(tdo),
  .ap_req(ap_req), .ap_ack(ap_ack), .ap_abort(ap_abort), .ap_wnr(ap_wnr),
  .ap_addr(ap_addr), .ap_wdata(ap_wdata), .pwr_req(pwr_req), .pwr_ack(pwr_ack)
);

// File: tb/dbgp_port_tb_top.sv
module dbgp_port_tb_top;
  localparam int TCK_PERIOD = 10;
  localparam logic [31:0] ID_VAL = 32'h1E5A_7C01;
  localparam logic [34:0] M_ALL = '1;
  localparam logic [34:0] M_ACK = 35'h7;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        tdo;
  logic        ap_req, ap_wnr, ap_abort;
  logic [13:0] ap_addr;
  logic [31:0] ap_wdata;
  logic        ap_ack = 1'b0;
  logic [31:0] ap_rdata = '0;
  logic        ap_err = 1'b0;

  always #(TCK_PERIOD/2) tck = ~tck;

  dbgp_port dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .ap_req(ap_req), .ap_wnr(ap_wnr), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
    .ap_ack(ap_ack), .ap_rdata(ap_rdata), .ap_err(ap_err), .ap_abort(ap_abort)
  );

  // ---------------- scoreboard ----------------
  typedef struct {
    string       tag;
    logic [34:0] exp;
    logic [34:0] msk;
  } exp_t;
  exp_t        exp_q[$];
  logic [34:0] act_q[$];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 0;

  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        exp_t        e;
        logic [34:0] a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_checks++;
        if ((a & e.msk) !== (e.exp & e.msk)) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h (mask %h)", e.tag, a & e.msk, e.exp & e.msk, e.msk);
        end
      end
    end
  end

  task automatic port_check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    exp_q.push_back('{tag, exp, M_ALL});
    act_q.push_back(act);
  endtask

  // ---------------- access-port emulator ----------------
  logic [31:0] apmem [0:63];
  bit          hold = 0;
  bit          err_next = 0;
  int          lat_cnt = 0;
  int          tx_cnt = 0;
  int          abort_cnt = 0;
  logic [13:0] last_addr = '0;
  logic [31:0] last_wdata = '0;
  logic        last_wnr = 1'b0;

  initial for (int i = 0; i < 64; i++) apmem[i] = 32'hA500_0000 | i;

  always @(negedge tck) begin
    if (ap_abort) abort_cnt++;
    if (ap_ack) begin
      ap_ack = 1'b0;
      ap_err = 1'b0;
    end else if (ap_req && !hold) begin
      if (lat_cnt >= 2) begin
        ap_ack = 1'b1;
        ap_err = err_next;
        err_next = 0;
        if (ap_wnr) apmem[ap_addr[5:0]] = ap_wdata;
        else        ap_rdata = apmem[ap_addr[5:0]];
        last_addr = ap_addr; last_wdata = ap_wdata; last_wnr = ap_wnr;
        tx_cnt++;
        lat_cnt = 0;
      end else lat_cnt++;
    end else if (!ap_req) lat_cnt = 0;
  end

  // ---------------- TAP driver ----------------
  task automatic step(input logic t, input logic d, output logic o);
    @(negedge tck);
    o = tdo; tms = t; tdi = d;
  endtask

  task automatic tap_reset();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
    logic o;
    step(1'b1, 1'b0, o); step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i], o);
      cap[i] = o;
    end
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
  endtask

  task automatic dr_scan(input int len, input logic [34:0] din, input int idle, output logic [34:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < idle; i++) step(1'b0, 1'b0, o);
  endtask

  // driver: push the expectation, run the scan, hand the result to the monitor
  task automatic acc(input string tag, input logic [34:0] frm, input logic [34:0] exp, input logic [34:0] msk);
    logic [34:0] r;
    exp_q.push_back('{tag, exp, msk});
    dr_scan(35, frm, 8, r);
    act_q.push_back(r);
  endtask

  task automatic set_ir(input logic [3:0] code);
    logic [3:0] c;
    ir_scan(code, c);
  endtask

  function automatic logic [34:0] fr(input logic [31:0] d, input logic [1:0] a, input logic rnw);
    return {d, a, rnw};
  endfunction

  function automatic logic [34:0] okd(input logic [31:0] d);
    return {d, 3'b010};
  endfunction

  localparam logic [34:0] WAITR = {32'h0, 3'b001};

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge tck);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [34:0] r;
    logic [3:0]  c;
    int          t0;

    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    repeat (3) @(negedge tck);
    // R13 reset state of tdo outside shift states
    port_check("R13 tdo idle after reset", {34'h0, tdo}, 35'h0);
    port_check("R6 no request after reset", {34'h0, ap_req}, 35'h0);
    tap_reset();

    // R1 R2: identification after reset without an IR scan
    exp_q.push_back('{"R1 R2 IDCODE default", {3'b0, ID_VAL}, {3'b0, 32'hFFFF_FFFF}});
    dr_scan(32, '0, 1, r);
    act_q.push_back(r);

    // R1: Capture-IR pattern
    ir_scan(4'h3, c);
    port_check("R1 capture-IR value", {31'h0, c}, 35'h1);

    // R2: bypass register, 1 bit capturing 0
    exp_q.push_back('{"R2 bypass path", 35'h2, 35'h3});
    dr_scan(2, 35'h3, 1, r);
    act_q.push_back(r);

    // R3 R4 R5: DP registers
    set_ir(4'hA);
    acc("R3 DP write SELECT ack", fr(32'hFFFF_FFFF, 2'b10, 1'b0), okd(32'h0), M_ALL);
    acc("R5 DP read SELECT", fr(32'h0, 2'b10, 1'b1), okd(32'h0), M_ALL);
    acc("R5 masked SELECT readback", fr(32'h0, 2'b11, 1'b1), okd(32'hFF00_00F0), M_ALL);
    acc("R5 DP write SELECT", fr(32'h0500_0030, 2'b10, 1'b0), okd(32'hFF00_00F0), M_ACK);
    acc("R5 DP read SELECT again", fr(32'h0, 2'b10, 1'b1), okd(32'h0), M_ACK);
    acc("R3 posted SELECT value", fr(32'h0, 2'b11, 1'b1), okd(32'h0500_0030), M_ALL);
    acc("R4 RDBUFF reread", fr(32'h0, 2'b11, 1'b1), okd(32'h0500_0030), M_ALL);
    acc("R4 RDBUFF write", fr(32'hFFFF_FFFF, 2'b11, 1'b0), okd(32'h0500_0030), M_ALL);
    acc("R4 RDBUFF write ignored", fr(32'h0, 2'b11, 1'b1), okd(32'h0500_0030), M_ALL);
    acc("R4 read addr 0", fr(32'h0, 2'b00, 1'b1), okd(32'h0500_0030), M_ALL);
    acc("R4 addr 0 reads zero", fr(32'h0, 2'b11, 1'b1), okd(32'h0), M_ALL);

    // R6: AP write with address from SELECT
    set_ir(4'hB);
    t0 = tx_cnt;
    acc("R6 AP write ack", fr(32'hCAFE_F00D, 2'b01, 1'b0), okd(32'h0), M_ALL);
    port_check("R6 one AP transfer", 35'(tx_cnt - t0), 35'd1);
    port_check("R5 R6 AP address", {21'h0, last_addr}, 35'h14D);
    port_check("R6 AP write data", {3'h0, last_wdata}, {3'h0, 32'hCAFE_F00D});
    port_check("R6 AP direction write", {34'h0, last_wnr}, 35'h1);

    // R3 R6: posted reads
    acc("R6 AP read first", fr(32'h0, 2'b01, 1'b1), okd(32'h0), M_ACK);
    acc("R3 AP read posts previous", fr(32'h0, 2'b10, 1'b1), okd(32'hCAFE_F00D), M_ALL);
    set_ir(4'hA);
    acc("R3 RDBUFF collects last read", fr(32'h0, 2'b11, 1'b1), okd(32'hA500_000E), M_ALL);

    // R7: WAIT while an access is open
    hold = 1;
    set_ir(4'hB);
    t0 = tx_cnt;
    acc("R7 launch held access", fr(32'h1, 2'b00, 1'b0), okd(32'h0), M_ACK);
    acc("R7 AP scan gets WAIT", fr(32'h2222, 2'b00, 1'b0), WAITR, M_ACK);
    set_ir(4'hA);
    acc("R7 DP scan gets WAIT", fr(32'h0, 2'b01, 1'b1), WAITR, M_ACK);
    port_check("R7 request still open", {34'h0, ap_req}, 35'h1);
    hold = 0;
    repeat (8) @(negedge tck);
    port_check("R7 discarded write never launched", 35'(tx_cnt - t0), 35'd1);
    port_check("R7 first write data", {3'h0, last_wdata}, 35'h1);
    acc("R8 CS read no detect", fr(32'h0, 2'b01, 1'b1), okd(32'h0), M_ACK);
    acc("R8 no overrun without detect", fr(32'h0, 2'b11, 1'b1), okd(32'h0), M_ALL);

    // R8: overrun detection
    acc("R8 enable detect", fr(32'h1, 2'b01, 1'b0), okd(32'h0), M_ACK);
    hold = 1;
    set_ir(4'hB);
    acc("R8 launch", fr(32'h5, 2'b00, 1'b0), okd(32'h0), M_ACK);
    acc("R8 WAIT with detect", fr(32'h6, 2'b00, 1'b0), WAITR, M_ACK);
    hold = 0;
    repeat (8) @(negedge tck);
    set_ir(4'hA);
    acc("R8 CS read", fr(32'h0, 2'b01, 1'b1), okd(32'h0), M_ACK);
    acc("R8 overrun flag set", fr(32'h0, 2'b11, 1'b1), okd(32'h3), M_ALL);

    // R9: sticky gate on AP requests
    set_ir(4'hB);
    t0 = tx_cnt;
    acc("R9 AP scan while sticky ack", fr(32'h77, 2'b00, 1'b0), okd(32'h0), M_ACK);
    port_check("R9 no launch while sticky", 35'(tx_cnt - t0), 35'd0);
    port_check("R9 request stays low", {34'h0, ap_req}, 35'h0);

    // R10: write-one-to-clear
    set_ir(4'hA);
    acc("R10 write zero keeps flag", fr(32'h1, 2'b01, 1'b0), okd(32'h0), M_ACK);
    acc("R10 CS read", fr(32'h0, 2'b01, 1'b1), okd(32'h0), M_ACK);
    acc("R10 flag kept", fr(32'h0, 2'b11, 1'b1), okd(32'h3), M_ALL);
    acc("R10 clear overrun", fr(32'h2, 2'b01, 1'b0), okd(32'h0), M_ACK);
    acc("R10 CS read", fr(32'h0, 2'b01, 1'b1), okd(32'h0), M_ACK);
    acc("R10 overrun cleared", fr(32'h0, 2'b11, 1'b1), okd(32'h0), M_ALL);

    // R9 R10: sticky error
    err_next = 1;
    set_ir(4'hB);
    acc("R9 AP read with error", fr(32'h0, 2'b00, 1'b1), okd(32'h0), M_ACK);
    set_ir(4'hA);
    acc("R9 CS read", fr(32'h0, 2'b01, 1'b1), okd(32'h0), M_ACK);
    acc("R9 sticky error set", fr(32'h0, 2'b11, 1'b1), okd(32'h20), M_ALL);
    acc("R10 clear error", fr(32'h20, 2'b01, 1'b0), okd(32'h0), M_ACK);
    acc("R10 CS read", fr(32'h0, 2'b01, 1'b1), okd(32'h0), M_ACK);
    acc("R10 error cleared", fr(32'h0, 2'b11, 1'b1), okd(32'h0), M_ALL);

    // R11: abort
    hold = 1;
    set_ir(4'hB);
    t0 = abort_cnt;
    acc("R11 launch held", fr(32'h9, 2'b00, 1'b0), okd(32'h0), M_ACK);
    set_ir(4'h8);
    acc("R11 abort value 2 ack", fr(32'h2, 2'b00, 1'b0), okd(32'h0), M_ALL);
    port_check("R11 non-one abort ignored", {34'h0, ap_req}, 35'h1);
    acc("R11 abort value 1 ack", fr(32'h1, 2'b00, 1'b0), okd(32'h0), M_ALL);
    port_check("R11 request dropped", {34'h0, ap_req}, 35'h0);
    port_check("R11 one abort pulse", 35'(abort_cnt - t0), 35'd1);
    hold = 0;
    set_ir(4'hB);
    acc("R11 port idle after abort", fr(32'h0, 2'b00, 1'b1), okd(32'h0), M_ACK);

    // R12: power request/acknowledge
    set_ir(4'hA);
    acc("R12 write power requests", fr(32'h5000_0000, 2'b01, 1'b0), okd(32'h0), M_ACK);
    acc("R12 CS read", fr(32'h0, 2'b01, 1'b1), okd(32'h0), M_ACK);
    acc("R12 acks follow requests", fr(32'h0, 2'b11, 1'b1), okd(32'hF000_0000), M_ALL);

    // R1: TAP reset restores the identification instruction
    tap_reset();
    exp_q.push_back('{"R1 IDCODE after TAP reset", {3'b0, ID_VAL}, {3'b0, 32'hFFFF_FFFF}});
    dr_scan(32, '0, 1, r);
    act_q.push_back(r);

    wait (act_q.size() == 0);
    #1;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule